// File: doc/BRIEF.md
# Package Idle State Coordinator

This block merges the idle codes reported by the threads of a processor package with an external stop-clock request. From them it picks one package low-power state: Normal, Stop-Grant or Deeper Sleep. Software enables two configuration bits, cache-size reduction and enhanced deep idle. Deeper Sleep is available only when both bits are set. When that holds, the block raises a deep-idle request toward the power sequencer as long as every thread sits in its deepest idle code.

A stop-clock request always wins. While it is active, the package sits in Stop-Grant, and each thread's arrival in its stop-grant code is recorded in a sticky flag. A window timer starts on the pulse that marks the response phase of the stop-grant acknowledge transaction. If some thread has not arrived when the window closes, a latency-violation flag is raised. The state held when stop-clock was first seen is stored, and the package returns to it when stop-clock is released.

Top module: `pkg_idle_coord`

## Requirements
- R1: Each thread reports a 3-bit code: 0 = active, 1 = halted, 2 = monitor-wait, 3 = light idle, 4 = deepest idle, 5 = stop-grant reached. The package state output is encoded 0 = Normal, 1 = Stop-Grant, 2 = Deeper Sleep. With stop-clock low and not every thread at code 4, the package state becomes 0 on the next clock edge, and stays at 0 after reset.
- R2: With stop-clock low, every thread at code 4 and both enable bits set, the package state becomes 2 on the next edge, and deep_req is high while those conditions persist.
- R3: If either enable bit is clear, deep_req stays low and the package state never becomes 2 through thread codes alone.
- R4: Stop-clock has priority. While it is high, deep_req is low in that same cycle, and the package state is 1 from the next edge on.
- R5: deep_req falls in the same cycle that any thread's code leaves 4, without waiting for a clock edge.
- R6: While stop-clock is high, the bit of sg_entered for a thread rises on the edge that samples that thread at code 5. It then holds even if the code changes. All bits clear on the first edge that samples stop-clock low. Code 5 while stop-clock is low has no effect on sg_entered.
- R7: On the first edge that samples stop-clock high, the package state in force before that edge is saved. On the first edge that samples stop-clock low again, the package state is set to the saved value. After that, normal evaluation resumes on the following edge.
- R8: The edge that samples ack_resp high while stop-clock is high is edge 0 of a window of SG_LIMIT edges. If any bit of sg_entered is still low just before edge SG_LIMIT, lat_violation rises on edge SG_LIMIT. If all bits are high earlier, the flag stays low.
- R9: lat_violation never rises without an acknowledge pulse, and it clears on the first edge that samples stop-clock low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_state | input | 3*NUM_THR | Idle codes, thread i in bits [3i+2:3i] |
| stop_req | input | 1 | External stop-clock request, active high |
| en_cache_size | input | 1 | Software enable: cache-size reduction |
| en_deep_idle | input | 1 | Software enable: enhanced deep idle |
| ack_resp | input | 1 | One-cycle pulse at the acknowledge response phase |
| pkg_state | output | 2 | Package state: 0 Normal, 1 Stop-Grant, 2 Deeper Sleep |
| deep_req | output | 1 | Deeper Sleep request |
| sg_entered | output | NUM_THR | Per-thread stop-grant arrival flags |
| lat_violation | output | 1 | Stop-grant window exceeded |

## Verification
The bench builds the block with two threads and SG_LIMIT set to 12 instead of 1384. With the short limit, the arrival edge of the late thread can be swept across every position of the window and a few edges beyond it. This checks both sides of the SG_LIMIT boundary exactly. With two threads, all 36 code pairs can be crossed with the four enable combinations. The save and restore path is exercised from both Normal and Deeper Sleep, including a release after the threads have left the deepest idle code.

// File: rtl/pkg_idle_pkg.sv
package pkg_idle_pkg;

   localparam int CODE_W = 3;

   localparam logic [CODE_W-1:0] TS_ACTIVE = 3'd0;
   localparam logic [CODE_W-1:0] TS_HALT   = 3'd1;
   localparam logic [CODE_W-1:0] TS_MWAIT  = 3'd2;
   localparam logic [CODE_W-1:0] TS_LIGHT  = 3'd3;
   localparam logic [CODE_W-1:0] TS_DEEP   = 3'd4;
   localparam logic [CODE_W-1:0] TS_SGNT   = 3'd5;

   typedef enum logic [1:0] {
      PKG_NORMAL = 2'd0,
      PKG_STOPGT = 2'd1,
      PKG_DEEP   = 2'd2
   } pkg_st_e;

endpackage

// File: rtl/thr_idle_track.sv
module thr_idle_track
   import pkg_idle_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code,
   input  logic              stop_req,
   output logic              at_deep,
   output logic              sg_flag
);

   assign at_deep = (code == TS_DEEP);

   // sticky arrival flag, live only while stop-clock is requested
   always_ff @(posedge clk) begin
      if (!rst_n)
         sg_flag <= 1'b0;
      else if (!stop_req)
         sg_flag <= 1'b0;
      else if (code == TS_SGNT)
         sg_flag <= 1'b1;
   end

   assert_flag_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sg_flag) |-> $past(stop_req && code == TS_SGNT));

   assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !stop_req |=> !sg_flag);

endmodule

// File: rtl/sg_window_timer.sv
module sg_window_timer #(
   parameter int LIMIT = 1384
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stop_req,
   input  logic ack_resp,
   input  logic all_sg,
   output logic viol
);

   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;
   logic          run_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !stop_req) begin
         cnt_q <= '0;
         run_q <= 1'b0;
         viol  <= 1'b0;
      end else if (ack_resp) begin
         cnt_q <= '0;
         run_q <= 1'b1;
      end else if (run_q) begin
         if (all_sg) begin
            run_q <= 1'b0;
         end else if (cnt_q == LAST) begin
            viol  <= 1'b1;
            run_q <= 1'b0;
            cnt_q <= cnt_q + 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(LIMIT));

   assert_viol_needs_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      viol |-> $past(stop_req));

   assert_viol_needs_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(viol) |-> $past(run_q && !all_sg));

endmodule

// File: rtl/pkg_state_fsm.sv
module pkg_state_fsm
   import pkg_idle_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    stop_req,
   input  logic    all_deep,
   input  logic    en_ok,
   output pkg_st_e pkg_q,
   output logic    deep_req
);

   logic    stop_q;
   pkg_st_e saved_q;
   pkg_st_e pkg_d;

   always_comb begin
      if (stop_req)
         pkg_d = PKG_STOPGT;
      else if (stop_q)
         pkg_d = saved_q;
      else if (all_deep && en_ok)
         pkg_d = PKG_DEEP;
      else
         pkg_d = PKG_NORMAL;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pkg_q   <= PKG_NORMAL;
         saved_q <= PKG_NORMAL;
         stop_q  <= 1'b0;
      end else begin
         pkg_q  <= pkg_d;
         stop_q <= stop_req;
         if (stop_req && !stop_q)
            saved_q <= pkg_q;
      end
   end

   // request drops combinationally when any thread leaves deep idle
   assign deep_req = (pkg_q == PKG_DEEP) && all_deep && en_ok && !stop_req;

   assert_sg_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req |=> pkg_q == PKG_STOPGT);

   assert_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop_req && stop_q) |=> pkg_q == $past(saved_q));

   assert_deep_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pkg_q == PKG_DEEP && !$past(stop_q)) |-> $past(all_deep && en_ok));

   assert_no_req_in_sg_R4: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req |-> !deep_req);

endmodule

// File: rtl/pkg_idle_coord.sv
module pkg_idle_coord
   import pkg_idle_pkg::*;
#(
   parameter int NUM_THR  = 2,
   parameter int SG_LIMIT = 1384
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_THR*CODE_W-1:0] thr_state,
   input  logic                      stop_req,
   input  logic                      en_cache_size,
   input  logic                      en_deep_idle,
   input  logic                      ack_resp,
   output logic [1:0]                pkg_state,
   output logic                      deep_req,
   output logic [NUM_THR-1:0]        sg_entered,
   output logic                      lat_violation
);

   generate
      if (NUM_THR < 1 || NUM_THR > 16) begin : g_bad_thr
         $error("pkg_idle_coord: NUM_THR out of range");
      end
      if (SG_LIMIT < 2) begin : g_bad_limit
         $error("pkg_idle_coord: SG_LIMIT must be at least 2");
      end
   endgenerate

   logic [NUM_THR-1:0] at_deep;
   pkg_st_e            pkg_q;
   logic               en_ok;

   assign en_ok = en_cache_size && en_deep_idle;

   for (genvar i = 0; i < NUM_THR; i++) begin : g_thr
      thr_idle_track u_trk (
         .clk      (clk),
         .rst_n    (rst_n),
         .code     (thr_state[i*CODE_W +: CODE_W]),
         .stop_req (stop_req),
         .at_deep  (at_deep[i]),
         .sg_flag  (sg_entered[i])
      );
   end

   pkg_state_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .stop_req (stop_req),
      .all_deep (&at_deep),
      .en_ok    (en_ok),
      .pkg_q    (pkg_q),
      .deep_req (deep_req)
   );

   sg_window_timer #(.LIMIT(SG_LIMIT)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .stop_req (stop_req),
      .ack_resp (ack_resp),
      .all_sg   (&sg_entered),
      .viol     (lat_violation)
   );

   assign pkg_state = pkg_q;

   assert_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      deep_req |-> (en_cache_size && en_deep_idle));

endmodule

// File: tb/pkg_idle_coord_test.sv
`timescale 1ns/1ps
module pkg_idle_coord_test;

   localparam int NT = 2;
   localparam int L  = 12;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NT*3-1:0] thr_state;
   logic          stop_req, en_cache_size, en_deep_idle, ack_resp;
   logic [1:0]    pkg_state;
   logic          deep_req;
   logic [NT-1:0] sg_entered;
   logic          lat_violation;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   pkg_idle_coord #(.NUM_THR(NT), .SG_LIMIT(L)) uut (
      .clk(clk), .rst_n(rst_n), .thr_state(thr_state), .stop_req(stop_req),
      .en_cache_size(en_cache_size), .en_deep_idle(en_deep_idle),
      .ack_resp(ack_resp), .pkg_state(pkg_state), .deep_req(deep_req),
      .sg_entered(sg_entered), .lat_violation(lat_violation)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic codes(input int t0, input int t1);
      thr_state = {3'(t1), 3'(t0)};
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin : main
      rst_n = 1'b0; stop_req = 1'b0; ack_resp = 1'b0;
      en_cache_size = 1'b0; en_deep_idle = 1'b0;
      codes(4, 4);
      repeat (3) step();
      chk("R1 reset state", pkg_state, 0);
      chk("R1 reset deep_req", deep_req, 0);
      chk("R6 reset flags", sg_entered, 0);
      chk("R9 reset viol", lat_violation, 0);
      rst_n = 1'b1;

      // R1 R2 R3 R6: sweep every code pair with every enable combination
      for (int e = 0; e < 4; e++) begin
         for (int a = 0; a < 6; a++) begin
            for (int b = 0; b < 6; b++) begin
               bit exp_deep;
               en_cache_size = e[0]; en_deep_idle = e[1];
               codes(a, b);
               step();
               exp_deep = (a == 4) && (b == 4) && (e == 3);
               chk("R1 R2 R3 sweep state", pkg_state, exp_deep ? 2 : 0);
               chk("R2 R3 sweep deep_req", deep_req, exp_deep);
               chk("R6 code 5 ignored without stop", sg_entered, 0);
            end
         end
      end

      // R5: same-cycle drop
      en_cache_size = 1'b1; en_deep_idle = 1'b1;
      codes(4, 4); step(); step();
      chk("R2 deep held", deep_req, 1);
      codes(0, 4); #1;
      chk("R5 deep_req drops before edge", deep_req, 0);
      chk("R5 state still deep before edge", pkg_state, 2);
      codes(4, 3); #1;
      chk("R5 other thread leaves", deep_req, 0);
      step();
      chk("R1 back to normal", pkg_state, 0);

      // R4: priority; R6 flags; R7 restore to Deeper Sleep
      codes(4, 4); step();
      chk("R2 deep again", pkg_state, 2);
      stop_req = 1'b1; #1;
      chk("R4 deep_req low same cycle", deep_req, 0);
      step();
      chk("R4 stop-grant wins", pkg_state, 1);
      chk("R4 deep_req low", deep_req, 0);
      codes(5, 4); step();
      chk("R6 thread0 flag", sg_entered, 1);
      codes(5, 5); step();
      chk("R6 both flags", sg_entered, 3);
      codes(0, 0); step();
      chk("R6 flags sticky", sg_entered, 3);
      chk("R4 stays stop-grant", pkg_state, 1);
      codes(4, 4); stop_req = 1'b0; step();
      chk("R7 restored deep", pkg_state, 2);
      chk("R7 deep_req after restore", deep_req, 1);
      chk("R6 flags cleared", sg_entered, 0);

      // R7: restore to Normal
      codes(0, 1); step();
      chk("R1 normal", pkg_state, 0);
      stop_req = 1'b1; step();
      chk("R4 stop-grant", pkg_state, 1);
      codes(4, 4); stop_req = 1'b0; step();
      chk("R7 restored normal", pkg_state, 0);
      step();
      chk("R2 resumes evaluation", pkg_state, 2);

      // R7: restore deep while threads have left deep idle
      stop_req = 1'b1; step();
      codes(0, 0); stop_req = 1'b0; step();
      chk("R7 restored deep stale", pkg_state, 2);
      chk("R5 no request after stale restore", deep_req, 0);
      step();
      chk("R7 then normal", pkg_state, 0);

      // R8: sweep arrival edge d of thread1 across the window
      for (int d = 0; d <= L + 3; d++) begin
         stop_req = 1'b0; codes(5, 0); step();
         stop_req = 1'b1; ack_resp = 1'b1;
         for (int ed = 0; ed <= L + 4; ed++) begin
            if (ed == d) codes(5, 5);
            step();
            ack_resp = 1'b0;
            if (ed == L - 1) chk("R8 no viol before window end", lat_violation, 0);
         end
         chk("R8 window boundary", lat_violation, (d >= L) ? 1 : 0);
      end
      stop_req = 1'b0; step();
      chk("R9 viol clears on release", lat_violation, 0);
      chk("R6 flags clear on release", sg_entered, 0);

      // R9: no pulse, no violation
      stop_req = 1'b1; codes(5, 0);
      repeat (3 * L) step();
      chk("R9 no viol without pulse", lat_violation, 0);
      chk("R6 partial flags", sg_entered, 1);
      stop_req = 1'b0; step();

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule